// File: doc/BRIEF.md
# Multi-Axis Step Schedule Player

This block executes queued stepper-motor motion schedules in hardware. A command holds a kind code, one direction bit for each motor and a list of up to 16 delay words. It enters a four-deep ring buffer in a single cycle, so the producer is free again at once. The player works only on the oldest command. It takes the delay words in list order. Each word waits the requested number of clock cycles, then sets the direction line of the motor that the word selects, then gives that motor one fixed-width step pulse.

Both motors share one interleaved delay stream. The most significant bit of each word names the motor that steps, and the remaining bits give the wait in clock cycles. After the last word of a command has played, the command is retired and the next one starts. A synchronous abort empties the queue. If a pulse is already high when abort arrives, that pulse still completes at full width.

Top module: `step_schedule_player`

## Requirements
- R1: After reset, every step and direction output is low. The queue reports empty, not full and level 0. busy is low and activeKind is 0.
- R2: Delay word bit 31 selects the motor (0 means stepOut[0], 1 means stepOut[1]). Bits 30:0 give the wait in clock cycles, and a wait of 0 counts as 1. When a command is captured into an idle, empty queue at clock edge P, its first step rises at edge P + 21 + wait.
- R3: The selected motor's dirOut bit takes that command's direction bit for the motor exactly 20 cycles before the step rises. The other motor's direction line is left unchanged.
- R4: Each step pulse stays high for exactly 100 cycles, and at most one step output is high at any time.
- R5: Within one command, consecutive step rising edges are 100 + 20 + wait(next word) cycles apart.
- R6: Words play in list order, and exactly pushCount of them play (up to 16). A command with count 0 is retired one cycle after capture and produces no step.
- R7: Commands play in first-in first-out order. The first step of the next command rises 100 + 1 + 20 + wait cycles after the previous command's last step rose.
- R8: queueLevel counts the stored commands. When 4 commands are stored, queueFull is high, and a push made then is dropped and never played.
- R9: When the queue is empty and the player is idle, all step outputs are low and the direction outputs keep their last values.
- R10: An abort while waiting or in setup leaves the queue empty and busy low on the next cycle, and no step pulse follows.
- R11: An abort during a pulse empties the queue on the next cycle. The running pulse still lasts the full 100 cycles, and no further step follows.
- R12: activeKind shows the kind of the head command while the queue holds one, and 0 when the queue is empty. busy is high while a command is stored or playing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| abort | input | 1 | Synchronous flush of queue and schedule |
| pushValid | input | 1 | Push a command this cycle |
| pushKind | input | 2 | Command kind code |
| pushDir | input | 2 | Direction bit per motor |
| pushCount | input | 5 | Number of valid delay words |
| pushDelays | input | 512 | Delay words, word e at bits [32e+31:32e] |
| stepOut | output | 2 | Step pulse per motor |
| dirOut | output | 2 | Direction line per motor |
| activeKind | output | 2 | Kind of the head command |
| busy | output | 1 | Command stored or playing |
| queueFull | output | 1 | Queue holds 4 commands |
| queueEmpty | output | 1 | Queue holds no command |
| queueLevel | output | 3 | Number of stored commands |

## Verification
Every timing result is tied to the clock edge that captured the push. A first step is due 21 + wait edges after capture. A later step in the same command is due 120 + wait edges after the previous rise, and the first step of a following command is due one edge later than that. A bench monitor samples at falling clock edges and records the edge number of each step rise and fall and of each direction change. The checks compare those edge numbers with the values the bench computes from the requirements. Queue status after a push, a count-0 retire or an abort is read at the first falling edge after the edge the result is due on.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  typedef struct packed {
    logic start;
    logic advance;
    logic latchDir;
    logic loadSetup;
    logic loadPulse;
    logic stepOn;
    logic pop;
    logic flush;
  } ssp_strobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_SETUP,
    ST_PULSE
  } ssp_state_t;

endpackage

// File: rtl/ssp_datapath.sv
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int NUM_MOTORS  = 2,
  parameter int KIND_W      = 2,
  parameter int DELAY_W     = 32,
  parameter int QUEUE_DEPTH = 4,
  parameter int MAX_ENTRIES = 16,
  parameter int DIR_SETUP   = 20,
  parameter int PULSE_LEN   = 100,
  localparam int MIDX_W = $clog2(NUM_MOTORS),
  localparam int WAIT_W = DELAY_W - MIDX_W,
  localparam int PTR_W  = $clog2(QUEUE_DEPTH),
  localparam int LVL_W  = $clog2(QUEUE_DEPTH + 1),
  localparam int CNT_W  = $clog2(MAX_ENTRIES + 1),
  localparam int EIDX_W = $clog2(MAX_ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           pushValid,
  input  logic [KIND_W-1:0]              pushKind,
  input  logic [NUM_MOTORS-1:0]          pushDir,
  input  logic [CNT_W-1:0]               pushCount,
  input  logic [MAX_ENTRIES*DELAY_W-1:0] pushDelays,
  input  ssp_strobe_t                    strb,
  output logic                           headValid,
  output logic                           headNoSteps,
  output logic                           lastEntry,
  output logic                           timerZero,
  output logic [NUM_MOTORS-1:0]          stepOut,
  output logic [NUM_MOTORS-1:0]          dirOut,
  output logic [KIND_W-1:0]              activeKind,
  output logic                           queueFull,
  output logic                           queueEmpty,
  output logic [LVL_W-1:0]               queueLevel
);

  logic [KIND_W-1:0]     kindMem  [QUEUE_DEPTH];
  logic [NUM_MOTORS-1:0] dirMem   [QUEUE_DEPTH];
  logic [CNT_W-1:0]      cntMem   [QUEUE_DEPTH];
  logic [DELAY_W-1:0]    delayMem [QUEUE_DEPTH][MAX_ENTRIES];

  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [LVL_W-1:0]  level;
  logic [EIDX_W-1:0] entryIdx, loadIdx;
  logic [MIDX_W-1:0] curMotor, loadMotor;
  logic [WAIT_W-1:0] timer, loadWait, loadVal;
  logic [DELAY_W-1:0] loadWord;
  logic [CNT_W-1:0]  storeCount;
  logic [NUM_MOTORS-1:0] dirReg;
  logic pushOk, popOk;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(QUEUE_DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign queueFull  = (level == LVL_W'(QUEUE_DEPTH));
  assign queueEmpty = (level == '0);
  assign queueLevel = level;
  assign headValid  = !queueEmpty;
  assign pushOk     = pushValid && !queueFull && !strb.flush;
  assign popOk      = strb.pop && headValid;
  assign storeCount = (pushCount > CNT_W'(MAX_ENTRIES)) ? CNT_W'(MAX_ENTRIES) : pushCount;

  // queue storage, written only on an accepted push
  always_ff @(posedge clk) begin
    if (pushOk) begin
      kindMem[wrPtr] <= pushKind;
      dirMem[wrPtr]  <= pushDir;
      cntMem[wrPtr]  <= storeCount;
      for (int e = 0; e < MAX_ENTRIES; e++)
        delayMem[wrPtr][e] <= pushDelays[e*DELAY_W +: DELAY_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      level <= '0;
    end else begin
      if (pushOk) wrPtr <= bump(wrPtr);
      if (popOk)  rdPtr <= bump(rdPtr);
      case ({pushOk, popOk})
        2'b10:   level <= level + LVL_W'(1);
        2'b01:   level <= level - LVL_W'(1);
        default: level <= level;
      endcase
    end
  end

  assign headNoSteps = (cntMem[rdPtr] == '0);
  assign lastEntry   = ((CNT_W'(entryIdx) + CNT_W'(1)) == cntMem[rdPtr]);
  assign activeKind  = headValid ? kindMem[rdPtr] : '0;

  // delay word selection: motor index on top, wait below
  assign loadIdx   = strb.advance ? entryIdx + EIDX_W'(1) : entryIdx;
  assign loadWord  = delayMem[rdPtr][loadIdx];
  assign loadMotor = loadWord[DELAY_W-1 -: MIDX_W];
  assign loadWait  = loadWord[WAIT_W-1:0];
  assign loadVal   = (loadWait == '0) ? '0 : loadWait - WAIT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryIdx <= '0;
      curMotor <= '0;
      timer    <= '0;
    end else begin
      if (strb.flush || popOk)      entryIdx <= '0;
      else if (strb.advance)        entryIdx <= loadIdx;

      if (strb.start || strb.advance) curMotor <= loadMotor;

      if (strb.start || strb.advance) timer <= loadVal;
      else if (strb.loadSetup)        timer <= WAIT_W'(DIR_SETUP - 1);
      else if (strb.loadPulse)        timer <= WAIT_W'(PULSE_LEN - 1);
      else if (timer != '0)           timer <= timer - WAIT_W'(1);
    end
  end

  assign timerZero = (timer == '0);

  always_ff @(posedge clk) begin
    if (!rstN)              dirReg <= '0;
    else if (strb.latchDir) dirReg[curMotor] <= dirMem[rdPtr][curMotor];
  end

  assign dirOut = dirReg;

  always_comb begin
    stepOut = '0;
    if (strb.stepOn) stepOut[curMotor] = 1'b1;
  end

endmodule

// File: rtl/ssp_control.sv
module ssp_control
  import ssp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        abort,
  input  logic        headValid,
  input  logic        headNoSteps,
  input  logic        lastEntry,
  input  logic        timerZero,
  output ssp_strobe_t strb,
  output logic        busy
);

  ssp_state_t state, nxtState;
  logic drain, nxtDrain;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      drain <= 1'b0;
    end else begin
      state <= nxtState;
      drain <= nxtDrain;
    end
  end

  always_comb begin
    strb        = '0;
    nxtState    = state;
    nxtDrain    = drain;
    strb.stepOn = (state == ST_PULSE);
    case (state)
      ST_IDLE: begin
        if (abort) strb.flush = 1'b1;
        else if (headValid) begin
          if (headNoSteps) strb.pop = 1'b1;
          else begin
            strb.start = 1'b1;
            nxtState   = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (abort) begin
          strb.flush = 1'b1;
          nxtState   = ST_IDLE;
        end else if (timerZero) begin
          strb.latchDir  = 1'b1;
          strb.loadSetup = 1'b1;
          nxtState       = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (abort) begin
          strb.flush = 1'b1;
          nxtState   = ST_IDLE;
        end else if (timerZero) begin
          strb.loadPulse = 1'b1;
          nxtState       = ST_PULSE;
        end
      end
      ST_PULSE: begin
        if (abort) begin
          strb.flush = 1'b1;
          nxtDrain   = 1'b1;
        end
        if (timerZero) begin
          if (abort || drain) begin
            nxtState = ST_IDLE;
            nxtDrain = 1'b0;
          end else if (lastEntry) begin
            strb.pop = 1'b1;
            nxtState = ST_IDLE;
          end else begin
            strb.advance = 1'b1;
            nxtState     = ST_WAIT;
          end
        end
      end
      default: nxtState = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE) || headValid;

endmodule

// File: rtl/step_schedule_player.sv
module step_schedule_player
  import ssp_pkg::*;
#(
  parameter int NUM_MOTORS  = 2,
  parameter int KIND_W      = 2,
  parameter int DELAY_W     = 32,
  parameter int QUEUE_DEPTH = 4,
  parameter int MAX_ENTRIES = 16,
  parameter int DIR_SETUP   = 20,
  parameter int PULSE_LEN   = 100,
  localparam int CNT_W = $clog2(MAX_ENTRIES + 1),
  localparam int LVL_W = $clog2(QUEUE_DEPTH + 1)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           abort,
  input  logic                           pushValid,
  input  logic [KIND_W-1:0]              pushKind,
  input  logic [NUM_MOTORS-1:0]          pushDir,
  input  logic [CNT_W-1:0]               pushCount,
  input  logic [MAX_ENTRIES*DELAY_W-1:0] pushDelays,
  output logic [NUM_MOTORS-1:0]          stepOut,
  output logic [NUM_MOTORS-1:0]          dirOut,
  output logic [KIND_W-1:0]              activeKind,
  output logic                           busy,
  output logic                           queueFull,
  output logic                           queueEmpty,
  output logic [LVL_W-1:0]               queueLevel
);

  ssp_strobe_t strb;
  logic headValid, headNoSteps, lastEntry, timerZero;

  ssp_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .abort      (abort),
    .headValid  (headValid),
    .headNoSteps(headNoSteps),
    .lastEntry  (lastEntry),
    .timerZero  (timerZero),
    .strb       (strb),
    .busy       (busy)
  );

  ssp_datapath #(
    .NUM_MOTORS (NUM_MOTORS),
    .KIND_W     (KIND_W),
    .DELAY_W    (DELAY_W),
    .QUEUE_DEPTH(QUEUE_DEPTH),
    .MAX_ENTRIES(MAX_ENTRIES),
    .DIR_SETUP  (DIR_SETUP),
    .PULSE_LEN  (PULSE_LEN)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pushValid  (pushValid),
    .pushKind   (pushKind),
    .pushDir    (pushDir),
    .pushCount  (pushCount),
    .pushDelays (pushDelays),
    .strb       (strb),
    .headValid  (headValid),
    .headNoSteps(headNoSteps),
    .lastEntry  (lastEntry),
    .timerZero  (timerZero),
    .stepOut    (stepOut),
    .dirOut     (dirOut),
    .activeKind (activeKind),
    .queueFull  (queueFull),
    .queueEmpty (queueEmpty),
    .queueLevel (queueLevel)
  );

endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
  parameter int NUM_MOTORS  = 2,
  parameter int QUEUE_DEPTH = 4,
  parameter int DIR_SETUP   = 20,
  parameter int PULSE_LEN   = 100,
  parameter int LVL_W       = 3,
  localparam int HC_W = $clog2(PULSE_LEN + 2),
  localparam int SC_W = $clog2(DIR_SETUP + 2)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  abort,
  input logic                  pushValid,
  input logic [NUM_MOTORS-1:0] stepOut,
  input logic [NUM_MOTORS-1:0] dirOut,
  input logic                  busy,
  input logic                  queueFull,
  input logic                  queueEmpty,
  input logic [LVL_W-1:0]      queueLevel
);

  logic [HC_W-1:0]       highCnt;
  logic [SC_W-1:0]       stableCnt;
  logic [NUM_MOTORS-1:0] prevDir;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highCnt   <= '0;
      stableCnt <= SC_W'(DIR_SETUP);
      prevDir   <= '0;
    end else begin
      prevDir <= dirOut;
      if (|stepOut) highCnt <= (highCnt == HC_W'(PULSE_LEN + 1)) ? highCnt : highCnt + HC_W'(1);
      else          highCnt <= '0;
      if (dirOut != prevDir)                 stableCnt <= '0;
      else if (stableCnt < SC_W'(DIR_SETUP)) stableCnt <= stableCnt + SC_W'(1);
    end
  end

  // R4
  one_step_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(stepOut));

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(|stepOut) |-> highCnt == HC_W'(PULSE_LEN));

  // R4
  pulse_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    highCnt <= HC_W'(PULSE_LEN));

  // R3
  dir_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|stepOut) |-> (dirOut == prevDir) && (stableCnt >= SC_W'(DIR_SETUP - 1)));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (queueEmpty && !busy) |-> stepOut == '0);

  // R10
  abort_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> queueEmpty);

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (queueFull && pushValid && !abort) |=> queueLevel <= $past(queueLevel));

  // R8
  level_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    queueLevel <= LVL_W'(QUEUE_DEPTH));

endmodule

bind step_schedule_player ssp_checker #(
  .NUM_MOTORS (NUM_MOTORS),
  .QUEUE_DEPTH(QUEUE_DEPTH),
  .DIR_SETUP  (DIR_SETUP),
  .PULSE_LEN  (PULSE_LEN),
  .LVL_W      (LVL_W)
) u_ssp_checker (
  .clk       (clk),
  .rstN      (rstN),
  .abort     (abort),
  .pushValid (pushValid),
  .stepOut   (stepOut),
  .dirOut    (dirOut),
  .busy      (busy),
  .queueFull (queueFull),
  .queueEmpty(queueEmpty),
  .queueLevel(queueLevel)
);

// File: tb/test_step_schedule_player.sv
`timescale 1ns/1ps
module test_step_schedule_player;
  localparam int DW = 32, ME = 16, SETUP = 20, PULSE = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic abort = 1'b0;
  logic pushValid = 1'b0;
  logic [1:0] pushKind = '0;
  logic [1:0] pushDir = '0;
  logic [4:0] pushCount = '0;
  logic [ME*DW-1:0] pushDelays = '0;
  logic [1:0] stepOut, dirOut, activeKind;
  logic busy, queueFull, queueEmpty;
  logic [2:0] queueLevel;

  always #2.5 clk = ~clk;

  step_schedule_player i_step_schedule_player (
    .clk(clk), .rstN(rstN), .abort(abort), .pushValid(pushValid),
    .pushKind(pushKind), .pushDir(pushDir), .pushCount(pushCount),
    .pushDelays(pushDelays), .stepOut(stepOut), .dirOut(dirOut),
    .activeKind(activeKind), .busy(busy), .queueFull(queueFull),
    .queueEmpty(queueEmpty), .queueLevel(queueLevel)
  );

  int cyc = 0;
  int nChecks = 0, nFail = 0;
  int evN = 0;
  int riseCyc [128];
  int riseMot [128];
  int riseDir [128];
  int riseGap [128];
  int widthOf [128];
  int lastChg [2] = '{-1000, -1000};
  logic [1:0] prevStep = '0, prevDir = '0;
  logic [DW-1:0] wbuf [ME];
  int pushCyc;

  always @(posedge clk) cyc <= cyc + 1;

  // event monitor, sampling away from the active edge
  always @(negedge clk) begin
    for (int m = 0; m < 2; m++) begin
      if (dirOut[m] != prevDir[m]) lastChg[m] = cyc;
      if (stepOut[m] && !prevStep[m]) begin
        riseCyc[evN] = cyc;
        riseMot[evN] = m;
        riseDir[evN] = int'(dirOut[m]);
        riseGap[evN] = cyc - lastChg[m];
        widthOf[evN] = -1;
        evN = evN + 1;
      end
      if (!stepOut[m] && prevStep[m] && evN > 0) widthOf[evN-1] = cyc - riseCyc[evN-1];
    end
    prevStep = stepOut;
    prevDir  = dirOut;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic logic [DW-1:0] mkWord(input int m, input int d);
    return {m[0], d[30:0]};
  endfunction

  task automatic pushCmd(input logic [1:0] kind, input logic [1:0] dirs, input int cnt);
    @(negedge clk);
    pushKind  = kind;
    pushDir   = dirs;
    pushCount = cnt[4:0];
    for (int e = 0; e < ME; e++) pushDelays[e*DW +: DW] = wbuf[e];
    pushValid = 1'b1;
    @(negedge clk);
    pushCyc   = cyc;
    pushValid = 1'b0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseAbort();
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (all requirements): actual cycle limit %0d expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

  initial begin
    int base, p;
    int d2 [4];
    int m2 [4];
    for (int e = 0; e < ME; e++) wbuf[e] = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(stepOut == 2'b00, "R1 step low", stepOut, 0);
    chk(dirOut == 2'b00, "R1 dir low", dirOut, 0);
    chk(queueEmpty && !queueFull, "R1 empty/full", {queueEmpty, queueFull}, 2);
    chk(queueLevel == 0, "R1 level", queueLevel, 0);
    chk(!busy && activeKind == 0, "R1 busy/kind", {busy, activeKind}, 0);

    // R2 R3 R4 R5 R12: one command, interleaved motors
    d2 = '{5, 0, 7, 3};
    m2 = '{0, 1, 1, 0};
    for (int e = 0; e < 4; e++) wbuf[e] = mkWord(m2[e], d2[e]);
    base = evN;
    pushCmd(2'd1, 2'b10, 4);
    p = pushCyc;
    chk(activeKind == 2'd1 && busy, "R12 kind while queued", activeKind, 1);
    waitIdle();
    chk(evN - base == 4, "R6 step count", evN - base, 4);
    chk(riseCyc[base] == p + 21 + eff(d2[0]), "R2 first rise", riseCyc[base] - p, 21 + eff(d2[0]));
    for (int i = 0; i < 4; i++) begin
      chk(riseMot[base+i] == m2[i], "R2 motor select", riseMot[base+i], m2[i]);
      chk(widthOf[base+i] == PULSE, "R4 pulse width", widthOf[base+i], PULSE);
      chk(riseDir[base+i] == (m2[i] == 1 ? 1 : 0), "R3 dir value", riseDir[base+i], m2[i]);
      if (i > 0)
        chk(riseCyc[base+i] - riseCyc[base+i-1] == PULSE + SETUP + eff(d2[i]), "R5 spacing",
            riseCyc[base+i] - riseCyc[base+i-1], PULSE + SETUP + eff(d2[i]));
    end
    chk(riseGap[base+1] == SETUP, "R3 dir setup", riseGap[base+1], SETUP);
    chk(dirOut == 2'b10, "R9 dir held", dirOut, 2);
    chk(stepOut == 0 && queueEmpty, "R9 idle quiet", stepOut, 0);
    chk(activeKind == 0, "R12 kind empty", activeKind, 0);

    // R6 count 0 retired
    base = evN;
    pushCmd(2'd2, 2'b01, 0);
    chk(!queueEmpty, "R6 zero-count captured", queueEmpty, 0);
    @(negedge clk);
    chk(queueEmpty && !busy, "R6 zero-count retired", {queueEmpty, busy}, 2);
    repeat (40) @(negedge clk);
    chk(evN == base && dirOut == 2'b10, "R6 zero-count no step", evN - base, 0);

    // R7 R8 queue order, full, drop
    base = evN;
    for (int i = 0; i < 4; i++) begin
      wbuf[0] = mkWord(i % 2, i + 2);
      pushCmd(2'((i + 1) % 4), 2'(i), 1);
    end
    chk(queueFull && queueLevel == 4, "R8 full at four", queueLevel, 4);
    chk(activeKind == 2'd1, "R12 head kind", activeKind, 1);
    wbuf[0] = mkWord(0, 9);
    pushCmd(2'd3, 2'b11, 1);
    chk(queueLevel == 4, "R8 push dropped", queueLevel, 4);
    waitIdle();
    chk(evN - base == 4, "R8 dropped never plays", evN - base, 4);
    for (int i = 0; i < 4; i++) begin
      chk(riseMot[base+i] == i % 2, "R7 fifo order", riseMot[base+i], i % 2);
      chk(riseDir[base+i] == ((i >> (i % 2)) & 1), "R3 dir per command", riseDir[base+i], (i >> (i % 2)) & 1);
      if (i > 0)
        chk(riseCyc[base+i] - riseCyc[base+i-1] == PULSE + 1 + SETUP + eff(i + 2), "R7 command gap",
            riseCyc[base+i] - riseCyc[base+i-1], PULSE + 1 + SETUP + eff(i + 2));
    end

    // R2 sweep over motors and short waits
    for (int m = 0; m < 2; m++) begin
      for (int d = 0; d < 10; d++) begin
        base = evN;
        wbuf[0] = mkWord(m, d);
        pushCmd(2'd0, 2'b11, 1);
        p = pushCyc;
        waitIdle();
        chk(evN - base == 1, "R2 sweep count", evN - base, 1);
        chk(riseCyc[base] - p == 21 + eff(d), "R2 sweep timing", riseCyc[base] - p, 21 + eff(d));
        chk(riseMot[base] == m, "R2 sweep motor", riseMot[base], m);
      end
    end

    // R10 abort while waiting
    base = evN;
    wbuf[0] = mkWord(0, 60);
    pushCmd(2'd1, 2'b00, 1);
    repeat (10) @(negedge clk);
    pulseAbort();
    chk(queueEmpty && !busy, "R10 flushed", {queueEmpty, busy}, 2);
    repeat (150) @(negedge clk);
    chk(evN == base && stepOut == 0, "R10 no pulse", evN - base, 0);
    chk(dirOut == 2'b11, "R10 dirs kept", dirOut, 3);

    // R11 abort mid pulse
    base = evN;
    for (int e = 0; e < 3; e++) wbuf[e] = mkWord(e % 2, 1);
    pushCmd(2'd2, 2'b11, 3);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (stepOut != 0) break;
    end
    repeat (30) @(negedge clk);
    pulseAbort();
    chk(queueEmpty, "R11 flushed", queueEmpty, 1);
    repeat (300) @(negedge clk);
    chk(evN - base == 1, "R11 no further step", evN - base, 1);
    chk(widthOf[base] == PULSE, "R11 full pulse", widthOf[base], PULSE);

    // R6 sixteen entries
    base = evN;
    for (int e = 0; e < ME; e++) wbuf[e] = mkWord(e % 2, 1);
    pushCmd(2'd3, 2'b00, 16);
    waitIdle();
    chk(evN - base == 16, "R6 sixteen entries", evN - base, 16);
    for (int i = 0; i < 16; i++) begin
      chk(riseMot[base+i] == i % 2, "R6 list order", riseMot[base+i], i % 2);
      chk(widthOf[base+i] == PULSE, "R4 width long cmd", widthOf[base+i], PULSE);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end

endmodule